// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the targets of subroutine returns in a core with a 48-bit instruction address space. A call event pushes the address of the instruction that follows the call. A return event pops the most recent entry, and the block presents it on a registered target output with a valid flag. The stack has a fixed depth. When it is full, new calls overwrite the oldest entry in a ring. When it is empty, the block can take a target from an external indirect-branch predictor, if the fallback input allows it.

A mode input selects between two kinds of entry. In full-width mode an entry keeps the whole address and is returned unchanged. In reduced-width mode an entry keeps only the low 32 bits. The upper 16 bits of the prediction are then taken from the address of the instruction that sequentially follows the return. A flush input discards every entry, so the next return finds the stack empty. Repairing mispredictions and checkpointing stack state across speculation are left to the surrounding front end.

Top module: `ras_pred`

## Requirements
- R1: Returns predict in last-in-first-out order. Each return without flush yields the most recent call address that has not yet been popped. The prediction appears on `pred_o`, with `pred_valid_o` high, in the cycle after the return is sampled.
- R2: The stack holds DEPTH=16 entries. A call on a full stack overwrites the oldest entry and `count_o` stays at 16. After 17 calls, 16 returns yield the last 16 addresses, newest first, and the 17th return finds the stack empty.
- R3: A return on an empty stack with `alt_en_i` low leaves `count_o` at 0 and drives `pred_valid_o` low in the next cycle.
- R4: A return on an empty stack with `alt_en_i` high drives `pred_o` to the `ind_tgt_i` value sampled with the return, with `pred_valid_o` high.
- R5: With `narrow_i` high, a call keeps only address bits 31:0, and bits 47:32 of the entry become zero. A return with `narrow_i` high predicts {`next_pc_i`[47:32], entry[31:0]}, using the `next_pc_i` sampled with the return.
- R6: With `narrow_i` low, the prediction equals the stored entry exactly.
- R7: A flush sets `count_o` to 0 in the next cycle and overrides a call or return in the same cycle. Neither of those takes effect, and `pred_valid_o` is low in the next cycle. The next return sees an empty stack.
- R8: When a call and a return arrive in the same cycle, the pop happens first and the push second. On a non-empty stack the old top is predicted, the new address replaces it, and `count_o` is unchanged. On an empty stack the empty handling applies and `count_o` becomes 1.
- R9: `count_o` gives the current occupancy, from 0 to 16. It reads 0 after reset and changes one cycle after the event that alters it.
- R10: `pred_valid_o` is high only in the cycle after a return sampled without flush. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call event: push `ret_addr_i` |
| ret_addr_i | input | 48 | Address of the instruction after the call |
| ret_i | input | 1 | Return event: pop and predict |
| next_pc_i | input | 48 | Address of the instruction after the return |
| alt_en_i | input | 1 | Allow the indirect-predictor target when the stack is empty |
| ind_tgt_i | input | 48 | Target offered by the indirect-branch predictor |
| narrow_i | input | 1 | 1: reduced-width entries, 0: full-width entries |
| flush_i | input | 1 | Empty the stack |
| pred_o | output | 48 | Predicted return target |
| pred_valid_o | output | 1 | `pred_o` carries a prediction for the previous cycle's return |
| count_o | output | 5 | Current occupancy |

## Verification
Each result of the block is due exactly one clock edge after the inputs that cause it. This holds for the prediction and its valid flag after a return, for the occupancy after a call, return or flush, and for the empty-stack fallback. The bench drives each stimulus on the falling edge. It waits for the next rising edge and samples one nanosecond after it, then compares against a reference stack updated for that same stimulus. The check therefore always looks at the registered result of the preceding cycle's event, never at a later or earlier one. The target value is compared only in cycles where the reference expects a valid prediction, so a held output does not produce false mismatches.

// File: rtl/ras_pkg.sv
`timescale 1ns/1ps
package ras_pkg;
  typedef struct packed {
    logic flush;
    logic push;
    logic pop;
  } ras_cmd_t;
endpackage

// File: rtl/ras_ctl.sv
`timescale 1ns/1ps
module ras_ctl
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ras_cmd_t      cmd_i,
  output logic          empty_o,
  output logic [PW-1:0] rd_idx_o,
  output logic [PW-1:0] wr_idx_o,
  output logic          wr_en_o,
  output logic [CW-1:0] cnt_o
);
  logic [PW-1:0] wp_q, wp_d, wp_inc, wp_dec;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign wp_inc  = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
  assign wp_dec  = (wp_q == '0) ? PW'(DEPTH - 1) : wp_q - PW'(1);
  assign pop_ok  = cmd_i.pop && !empty_o;

  assign rd_idx_o = wp_dec;
  // pop-then-push reuses the popped slot
  assign wr_idx_o = pop_ok ? wp_dec : wp_q;
  assign wr_en_o  = cmd_i.push && !cmd_i.flush;
  assign cnt_o    = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    cnt_d = cnt_q;
    if (cmd_i.flush) begin
      wp_d  = '0;
      cnt_d = '0;
    end else if (cmd_i.push && pop_ok) begin
      wp_d  = wp_q;
    end else if (cmd_i.push) begin
      wp_d = wp_inc;
      if (!full) cnt_d = cnt_q + CW'(1);
    end else if (pop_ok) begin
      wp_d  = wp_dec;
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end

  // R7
  flush_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.flush |=> (cnt_q == '0));

  // R8
  swap_keeps_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.push && cmd_i.pop && !cmd_i.flush && !empty_o) |=> $stable(cnt_q));

  // R2
  full_saturates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && cmd_i.push && !cmd_i.pop && !cmd_i.flush) |=> (cnt_q == CW'(DEPTH)));

  // R3
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && cmd_i.pop && !cmd_i.push && !cmd_i.flush) |=> (cnt_q == '0));

  // R9
  count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i.push && !cmd_i.pop && !cmd_i.flush && !full) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/ras_store.sv
`timescale 1ns/1ps
module ras_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 48,
  parameter int NW    = 32,
  parameter int PW    = 4
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          narrow_i,
  input  logic [PW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);
  logic [NW-1:0] lo_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) lo_q[wr_idx_i] <= wr_data_i[NW-1:0];
  end

  if (AW > NW) begin : g_hi
    logic [AW-NW-1:0] hi_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_en_i) hi_q[wr_idx_i] <= narrow_i ? '0 : wr_data_i[AW-1:NW];
    end
    assign rd_data_o = {hi_q[rd_idx_i], lo_q[rd_idx_i]};
  end else begin : g_flat
    assign rd_data_o = lo_q[rd_idx_i];
  end
endmodule

// File: rtl/ras_recon.sv
`timescale 1ns/1ps
module ras_recon #(
  parameter int AW = 48,
  parameter int NW = 32
) (
  input  logic [AW-1:0] entry_i,
  input  logic [AW-1:0] next_pc_i,
  input  logic [AW-1:0] ind_tgt_i,
  input  logic          narrow_i,
  input  logic          empty_i,
  input  logic          alt_en_i,
  output logic [AW-1:0] tgt_o,
  output logic          hit_o
);
  always_comb begin
    if (empty_i) begin
      tgt_o = ind_tgt_i;
      hit_o = alt_en_i;
    end else begin
      hit_o = 1'b1;
      tgt_o = narrow_i ? {next_pc_i[AW-1:NW], entry_i[NW-1:0]} : entry_i;
    end
  end
endmodule

// File: rtl/ras_pred.sv
`timescale 1ns/1ps
module ras_pred
  import ras_pkg::*;
#(
  parameter int AW    = 48,
  parameter int NW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic [AW-1:0] ret_addr_i,
  input  logic          ret_i,
  input  logic [AW-1:0] next_pc_i,
  input  logic          alt_en_i,
  input  logic [AW-1:0] ind_tgt_i,
  input  logic          narrow_i,
  input  logic          flush_i,
  output logic [AW-1:0] pred_o,
  output logic          pred_valid_o,
  output logic [CW-1:0] count_o
);
  ras_cmd_t      cmd;
  logic          empty, wr_en, hit;
  logic [PW-1:0] rd_idx, wr_idx;
  logic [AW-1:0] entry, tgt;

  assign cmd = '{flush: flush_i, push: call_i, pop: ret_i};

  ras_ctl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .empty_o  (empty),
    .rd_idx_o (rd_idx),
    .wr_idx_o (wr_idx),
    .wr_en_o  (wr_en),
    .cnt_o    (count_o)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW), .NW(NW), .PW(PW)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (ret_addr_i),
    .narrow_i  (narrow_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (entry)
  );

  ras_recon #(.AW(AW), .NW(NW)) u_recon (
    .entry_i   (entry),
    .next_pc_i (next_pc_i),
    .ind_tgt_i (ind_tgt_i),
    .narrow_i  (narrow_i),
    .empty_i   (empty),
    .alt_en_i  (alt_en_i),
    .tgt_o     (tgt),
    .hit_o     (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_o       <= '0;
      pred_valid_o <= 1'b0;
    end else if (flush_i) begin
      pred_valid_o <= 1'b0;
    end else if (ret_i) begin
      pred_valid_o <= hit;
      if (hit) pred_o <= tgt;
    end else begin
      pred_valid_o <= 1'b0;
    end
  end

  // R10
  valid_needs_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> $past(ret_i && !flush_i));

  // R3
  empty_no_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !flush_i && empty && !alt_en_i) |=> !pred_valid_o);

  // R4
  empty_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !flush_i && empty && alt_en_i) |=> (pred_valid_o && pred_o == $past(ind_tgt_i)));

  // R7
  flush_kills_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !pred_valid_o);
endmodule

// File: tb/ras_pred_tb.sv
`timescale 1ns/1ps
module ras_pred_tb_top;
  localparam int AW = 48;
  localparam int DEPTH = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          call_i = 1'b0, ret_i = 1'b0, alt_en_i = 1'b0, narrow_i = 1'b0, flush_i = 1'b0;
  logic [AW-1:0] ret_addr_i = '0, next_pc_i = '0, ind_tgt_i = '0;
  logic [AW-1:0] pred_o;
  logic          pred_valid_o;
  logic [4:0]    count_o;

  int vectors = 0;
  int errors  = 0;
  logic [AW-1:0] model_q[$];

  always #2.5 clk_i = ~clk_i;

  ras_pred dut_i (
    .clk_i, .rst_ni, .call_i, .ret_addr_i, .ret_i, .next_pc_i, .alt_en_i,
    .ind_tgt_i, .narrow_i, .flush_i, .pred_o, .pred_valid_o, .count_o
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference stack: returns expected valid/target after one event
  function automatic logic [AW:0] model_step(input logic c, input logic [AW-1:0] a, input logic r,
                                            input logic [AW-1:0] npc, input logic alt,
                                            input logic [AW-1:0] ind, input logic nar, input logic fl);
    logic [AW-1:0] t;
    logic          v;
    t = '0; v = 1'b0;
    if (fl) begin
      model_q.delete();
    end else begin
      if (r) begin
        if (model_q.size() > 0) begin
          t = model_q.pop_back();
          if (nar) t = {npc[47:32], t[31:0]};
          v = 1'b1;
        end else if (alt) begin
          t = ind; v = 1'b1;
        end
      end
      if (c) begin
        model_q.push_back(nar ? {16'h0, a[31:0]} : a);
        if (model_q.size() > DEPTH) void'(model_q.pop_front());
      end
    end
    return {v, t};
  endfunction

  task automatic step(input string tag, input logic c, input logic [AW-1:0] a, input logic r,
                      input logic [AW-1:0] npc, input logic alt, input logic [AW-1:0] ind,
                      input logic nar, input logic fl);
    logic [AW:0] e;
    call_i = c; ret_addr_i = a; ret_i = r; next_pc_i = npc;
    alt_en_i = alt; ind_tgt_i = ind; narrow_i = nar; flush_i = fl;
    e = model_step(c, a, r, npc, alt, ind, nar, fl);
    @(posedge clk_i);
    #1;
    chk(tag, "valid", {63'h0, pred_valid_o}, {63'h0, e[AW]});
    if (e[AW]) chk(tag, "target", {16'h0, pred_o}, {16'h0, e[AW-1:0]});
    chk(tag, "count", {59'h0, count_o}, 64'(model_q.size()));
    @(negedge clk_i);
  endtask

  task automatic push(input string tag, input logic [AW-1:0] a, input logic nar);
    step(tag, 1'b1, a, 1'b0, '0, 1'b0, '0, nar, 1'b0);
  endtask

  task automatic pop(input string tag, input logic [AW-1:0] npc, input logic alt,
                     input logic [AW-1:0] ind, input logic nar);
    step(tag, 1'b0, '0, 1'b1, npc, alt, ind, nar, 1'b0);
  endtask

  task automatic do_flush(input string tag);
    step(tag, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R9", "reset count", {59'h0, count_o}, 64'h0);
    chk("R10", "reset valid", {63'h0, pred_valid_o}, 64'h0);
    @(negedge clk_i);

    // R1 / R6: ordering, full width exact
    push("R1", 48'hA000_0000_0010, 1'b0);
    push("R1", 48'hB111_2222_3330, 1'b0);
    push("R6", 48'hFFFF_0000_0004, 1'b0);
    pop("R6", 48'h1234_5678_9ABC, 1'b0, '0, 1'b0);
    pop("R1", '0, 1'b0, '0, 1'b0);
    pop("R1", '0, 1'b0, '0, 1'b0);

    // R3 / R4: empty handling
    pop("R3", '0, 1'b0, 48'hDEAD_BEEF_0000, 1'b0);
    pop("R4", '0, 1'b1, 48'hCAFE_F00D_1234, 1'b0);
    pop("R4", 48'h5555_0000_0000, 1'b1, 48'h0000_0000_0040, 1'b1);

    // R2: wrap-around on overflow
    for (int i = 0; i < 17; i++) push("R2", 48'h0100_0000_0000 + 48'(i * 16), 1'b0);
    for (int i = 0; i < 17; i++) pop("R2", '0, 1'b0, '0, 1'b0);

    // R5: reduced width rebuild
    push("R5", 48'hABCD_1234_5678, 1'b1);
    push("R5", 48'h0F0F_FFFF_0000, 1'b1);
    pop("R5", 48'h7777_0000_0010, 1'b0, '0, 1'b1);
    pop("R5", 48'h2468_0000_0020, 1'b0, '0, 1'b1);
    push("R5", 48'h9999_0000_0100, 1'b1);
    pop("R5", 48'h1111_0000_0000, 1'b0, '0, 1'b0);

    // R8: same-cycle call and return
    push("R8", 48'h0000_0000_1000, 1'b0);
    push("R8", 48'h0000_0000_2000, 1'b0);
    step("R8", 1'b1, 48'h0000_0000_3000, 1'b1, '0, 1'b0, '0, 1'b0, 1'b0);
    pop("R8", '0, 1'b0, '0, 1'b0);
    pop("R8", '0, 1'b0, '0, 1'b0);
    step("R8", 1'b1, 48'h0000_0000_4000, 1'b1, '0, 1'b1, 48'h0000_0000_0BAD, 1'b0, 1'b0);
    for (int i = 0; i < 15; i++) push("R8", 48'h0000_0001_0000 + 48'(i), 1'b0);
    step("R8", 1'b1, 48'h0000_0002_0000, 1'b1, '0, 1'b0, '0, 1'b0, 1'b0);

    // R7: flush wins over call and return
    step("R7", 1'b1, 48'h0000_0003_0000, 1'b1, '0, 1'b1, 48'h1, 1'b0, 1'b1);
    pop("R7", '0, 1'b0, '0, 1'b0);
    push("R7", 48'h0000_0004_0000, 1'b0);
    do_flush("R7");
    pop("R7", '0, 1'b1, 48'h0000_0005_0000, 1'b0);

    // random mix
    begin
      logic nar;
      nar = 1'b0;
      for (int n = 0; n < 2000; n++) begin
        int unsigned rc, rr, rf;
        if (n % 200 == 0) nar = 1'($urandom_range(0, 1));
        rc = $urandom_range(0, 99);
        rr = $urandom_range(0, 99);
        rf = $urandom_range(0, 99);
        step("R1", rc < 45, {16'($urandom), $urandom}, rr < 40,
             {16'($urandom), $urandom}, 1'($urandom_range(0, 1)),
             {16'($urandom), $urandom}, nar, rf < 2);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule